// File: doc/BRIEF.md
# Sample-Rate Ratio Estimator with Deadband

This block measures how fast an output sample strobe runs relative to an input sample strobe. Both strobes are single-cycle pulses on the system clock. A measurement window spans a fixed number of input strobes. The number of output strobes seen in that window is the raw count. A downsampling converter uses the resulting ratio to stretch its filter.

When the raw count is larger than the window, the output is faster than the input. In that case the published ratio is pinned to exactly one. When the raw count is at or below the window, the ratio is the count divided by the window. It is an unsigned fixed-point value with a configurable number of fractional bits, computed by a sequential divider. A deadband of two output periods around the last accepted count keeps the ratio from flipping between neighbouring values. Without it, the filter length would keep changing.

Each change of the held ratio is announced by a one-cycle update pulse. The first measurement after reset is always taken.

Top module: `srr_est`

## Requirements
- R1: A window closes on the WINDOW-th input strobe since reset or since the previous close. The raw count is the number of output strobes from the cycle after the previous close up to and including the closing cycle. An output strobe that coincides with the closing input strobe is therefore counted in the closing window.
- R2: A ratio produced by division equals floor(count × 2^FRAC / WINDOW). It is FRAC+1 bits wide, with bit FRAC worth one, and it never exceeds 2^FRAC.
- R3: A raw count greater than WINDOW forces the ratio to exactly 2^FRAC (unity), with no deadband applied.
- R4: A unity-forcing count produces no update when the last accepted count already equals WINDOW.
- R5: For a raw count at or below WINDOW, the ratio is replaced only if the absolute difference from the last accepted count is strictly greater than 2. A difference of exactly 2 leaves the ratio and the reference count unchanged.
- R6: The first measurement after reset is always accepted and announced with an update pulse, even when its value equals the reset value.
- R7: The update output is high for exactly one cycle per accepted measurement. The ratio output changes only in a cycle where the update output is high.
- R8: During and right after reset, the ratio reads 2^FRAC and the update output reads 0.
- R9: A raw count exactly equal to WINDOW goes through the deadband path and yields unity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | 1 | Input sample strobe, one cycle wide |
| out_stb | input | 1 | Output sample strobe, one cycle wide |
| ratio | output | FRAC+1 | Held ratio, fixed point with FRAC fractional bits |
| ratio_upd | output | 1 | One-cycle pulse when a measurement is accepted |

## Verification
The embedded assertions check four things on every cycle:
- the update pulse is one cycle wide;
- the ratio moves only together with that pulse;
- the ratio stays at or below unity;
- the divider is never restarted while busy, and the first-measurement flag clears once used.

Only the bench scenarios can show the following:
- window boundaries, including strobes that coincide on the closing cycle;
- the exact quotient;
- the strict deadband, with differences of two and three;
- unity forcing and its suppression;
- re-acceptance of the first measurement after a reset.

The scoreboard predicts each update from a model of the deadband, which is built from the requirements alone.

// File: rtl/srr_pkg.sv
package srr_pkg;

    // Action chosen when a measurement window closes
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_UNITY  = 2'd1,
        ACT_DIVIDE = 2'd2
    } srr_act_e;

    // Closed-window measurement handed from counter to decider
    typedef struct packed {
        logic        vld;
        logic [31:0] cnt;
    } srr_meas_t;

    // Absolute difference of two counts
    function automatic logic [31:0] srr_absdiff(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // True when a count has left the deadband around the reference
    function automatic logic srr_outside_band(input logic [31:0] a, input logic [31:0] b,
                                              input int unsigned band);
        return srr_absdiff(a, b) > band;
    endfunction

endpackage

// File: rtl/srr_window_cnt.sv
module srr_window_cnt #(
    parameter int WINDOW = 256,
    parameter int CNT_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_stb,
    input  logic                      out_stb,
    output srr_pkg::srr_meas_t        meas
);
    import srr_pkg::*;

    localparam int IW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [IW-1:0] LAST_IN = IW'(WINDOW - 1);

    logic [IW-1:0]    in_cnt;
    logic [CNT_W-1:0] out_cnt;
    logic [CNT_W-1:0] out_cnt_nx;

    // saturating increment so a very fast output clock cannot wrap the count
    always_comb begin
        out_cnt_nx = out_cnt;
        if (out_stb && (out_cnt != {CNT_W{1'b1}}))
            out_cnt_nx = out_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt   <= '0;
            out_cnt  <= '0;
            meas.vld <= 1'b0;
            meas.cnt <= '0;
        end else begin
            meas.vld <= 1'b0;
            if (in_stb && (in_cnt == LAST_IN)) begin
                // R1: closing cycle includes a coincident output strobe
                in_cnt   <= '0;
                out_cnt  <= '0;
                meas.vld <= 1'b1;
                meas.cnt <= 32'(out_cnt_nx);
            end else begin
                if (in_stb)
                    in_cnt <= in_cnt + 1'b1;
                out_cnt <= out_cnt_nx;
            end
        end
    end

    a_r1_meas_single: assert property (@(posedge clk) disable iff (rst)
        meas.vld |=> !meas.vld);

endmodule

// File: rtl/srr_decider.sv
module srr_decider #(
    parameter int WINDOW = 256,
    parameter int CNT_W  = 12,
    parameter int BAND   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  srr_pkg::srr_meas_t   meas,
    output logic                 take_unity,
    output logic                 div_start,
    output logic [CNT_W-1:0]     div_cnt
);
    import srr_pkg::*;

    localparam logic [31:0] WIN32 = 32'(WINDOW);

    logic        first;
    logic [31:0] ref_cnt;
    srr_act_e    act;

    always_comb begin
        act = ACT_HOLD;
        if (meas.vld) begin
            if (meas.cnt > WIN32) begin
                // R3 / R4: unity forced, suppressed if already at unity reference
                if (first || (ref_cnt != WIN32))
                    act = ACT_UNITY;
            end else if (first || srr_outside_band(meas.cnt, ref_cnt, BAND)) begin
                // R5 / R6 / R9: deadband path
                act = ACT_DIVIDE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first      <= 1'b1;
            ref_cnt    <= '0;
            take_unity <= 1'b0;
            div_start  <= 1'b0;
            div_cnt    <= '0;
        end else begin
            take_unity <= (act == ACT_UNITY);
            div_start  <= (act == ACT_DIVIDE);
            if (act != ACT_HOLD)
                first <= 1'b0;
            if (act == ACT_UNITY)
                ref_cnt <= WIN32;
            if (act == ACT_DIVIDE) begin
                ref_cnt <= meas.cnt;
                div_cnt <= CNT_W'(meas.cnt);
            end
        end
    end

    a_r6_first_clears: assert property (@(posedge clk) disable iff (rst)
        (meas.vld && first) |=> (!first && (take_unity || div_start)));

    a_r7_one_action: assert property (@(posedge clk) disable iff (rst)
        !(take_unity && div_start));

endmodule

// File: rtl/srr_divider.sv
module srr_divider #(
    parameter int WINDOW = 256,
    parameter int CNT_W  = 12,
    parameter int FRAC   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt,
    output logic              done,
    output logic [FRAC:0]     quo
);
    localparam int NUM_W = CNT_W + FRAC;
    localparam int DW    = $clog2(WINDOW + 1);
    localparam int LW    = $clog2(NUM_W + 1);
    localparam logic [DW:0] DEN = (DW+1)'(WINDOW);

    logic             busy;
    logic [LW-1:0]    left;
    logic [NUM_W-1:0] num_sh;
    logic [NUM_W-1:0] q;
    logic [DW-1:0]    rem;
    logic [DW:0]      trial;
    logic [DW:0]      diff;
    logic             fits;

    always_comb begin
        trial = {rem, num_sh[NUM_W-1]};
        fits  = (trial >= DEN);
        diff  = trial - DEN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            left   <= '0;
            num_sh <= '0;
            q      <= '0;
            rem    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                left   <= LW'(NUM_W);
                num_sh <= {cnt, {FRAC{1'b0}}};
                q      <= '0;
                rem    <= '0;
            end else if (busy) begin
                num_sh <= num_sh << 1;
                q      <= {q[NUM_W-2:0], fits};
                rem    <= fits ? diff[DW-1:0] : trial[DW-1:0];
                left   <= left - 1'b1;
                if (left == LW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = q[FRAC:0];

    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    a_r2_quo_fits: assert property (@(posedge clk) disable iff (rst)
        done |-> (q[NUM_W-1:FRAC+1] == '0));

endmodule

// File: rtl/srr_est.sv
module srr_est #(
    parameter int WINDOW = 256,
    parameter int FRAC   = 20,
    parameter int MAX_UP = 8,
    parameter int BAND   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_stb,
    input  logic          out_stb,
    output logic [FRAC:0] ratio,
    output logic          ratio_upd
);
    import srr_pkg::*;

    localparam int CNT_W = $clog2(WINDOW * MAX_UP + 1);
    localparam logic [FRAC:0] UNITY = (FRAC+1)'(1) << FRAC;

    srr_meas_t        meas;
    logic             take_unity;
    logic             div_start;
    logic [CNT_W-1:0] div_cnt;
    logic             div_done;
    logic [FRAC:0]    div_quo;

    srr_window_cnt #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb), .meas(meas));

    srr_decider #(.WINDOW(WINDOW), .CNT_W(CNT_W), .BAND(BAND)) u_dec (
        .clk(clk), .rst(rst), .meas(meas), .take_unity(take_unity),
        .div_start(div_start), .div_cnt(div_cnt));

    srr_divider #(.WINDOW(WINDOW), .CNT_W(CNT_W), .FRAC(FRAC)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .cnt(div_cnt),
        .done(div_done), .quo(div_quo));

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio     <= UNITY;
            ratio_upd <= 1'b0;
        end else begin
            ratio_upd <= 1'b0;
            if (take_unity) begin
                ratio     <= UNITY;
                ratio_upd <= 1'b1;
            end else if (div_done) begin
                ratio     <= div_quo;
                ratio_upd <= 1'b1;
            end
        end
    end

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
        ratio_upd |=> !ratio_upd);

    a_r7_moves_with_pulse: assert property (@(posedge clk) disable iff (rst)
        (ratio != $past(ratio)) |-> ratio_upd);

    a_r2_not_above_unity: assert property (@(posedge clk) disable iff (rst)
        ratio <= UNITY);

endmodule

// File: tb/srr_est_bench.sv
module srr_est_bench;
    localparam int WINDOW = 256;
    localparam int FRAC   = 20;
    localparam logic [FRAC:0] UNITY = (FRAC+1)'(1) << FRAC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_stb = 1'b0;
    logic out_stb = 1'b0;
    logic [FRAC:0] ratio;
    logic ratio_upd;

    always #10 clk = ~clk;  // 50 MHz

    srr_est #(.WINDOW(WINDOW), .FRAC(FRAC)) u_srr_est (
        .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb),
        .ratio(ratio), .ratio_upd(ratio_upd));

    int n_vec = 0;
    int n_bad = 0;
    logic [FRAC:0] exp_q[$];
    string         tag_q[$];

    // model state, derived from the requirements
    bit            m_first = 1'b1;
    int            m_ref   = 0;
    logic [FRAC:0] m_held  = UNITY;

    task automatic check(input string req, input logic [FRAC:0] act, input logic [FRAC:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops one expected value per update pulse
    always @(negedge clk) begin
        if (!rst && ratio_upd) begin
            if (exp_q.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R7: actual unexpected update %0d expected none", ratio);
            end else begin
                check(tag_q.pop_front(), ratio, exp_q.pop_front());
            end
        end
    end

    // driver: one window of WINDOW input strobes carrying k output strobes
    task automatic run_window(input int k, input string req);
        int span = (k > WINDOW) ? k : WINDOW;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            in_stb  = (i >= span - WINDOW);
            out_stb = (i >= span - k);
        end
        @(negedge clk);
        in_stb  = 1'b0;
        out_stb = 1'b0;
        // expected outcome
        if (k > WINDOW) begin
            if (m_first || m_ref != WINDOW) begin
                exp_q.push_back(UNITY);
                tag_q.push_back(req);
                m_held = UNITY;
            end
            m_ref   = WINDOW;
            m_first = 1'b0;
        end else begin
            int d = (k > m_ref) ? k - m_ref : m_ref - k;
            if (m_first || d > 2) begin
                logic [FRAC:0] q = (FRAC+1)'((longint'(k) << FRAC) / WINDOW);
                exp_q.push_back(q);
                tag_q.push_back(req);
                m_held  = q;
                m_ref   = k;
                m_first = 1'b0;
            end
        end
        repeat (60) @(negedge clk);
        check({req, " held"}, ratio, m_held);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 ratio in reset", ratio, UNITY);
        check("R8 upd in reset", {{FRAC{1'b0}}, ratio_upd}, '0);
        rst = 1'b0;
        m_first = 1'b1;
        m_ref   = 0;
        m_held  = UNITY;
        @(negedge clk);
        check("R8 ratio after reset", ratio, UNITY);
    endtask

    bit finished = 1'b0;

    initial begin
        do_reset();
        run_window(128, "R6 first accept");
        run_window(130, "R5 diff two up");
        run_window(126, "R5 diff two down");
        run_window(131, "R5 diff three");
        run_window(300, "R3 unity forced");
        run_window(400, "R4 unity suppressed");
        run_window(256, "R9 equal count");
        run_window(254, "R5 diff two below unity");
        run_window(253, "R2 quotient 253");
        run_window(256, "R9 equal via divider");
        run_window(257, "R4 unity after equal");
        run_window(0,   "R2 zero count");
        run_window(1,   "R5 diff one");
        run_window(3,   "R1 coincident strobe count 3");
        run_window(77,  "R2 quotient 77");
        do_reset();
        run_window(300, "R6 first unity pulses");
        do_reset();
        run_window(255, "R6 first after reset");
        repeat (20) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7: actual %0d pending expected 0 pending", exp_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule